// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Port

This block is the interrupt front end of an eight-pin general-purpose input port. Each pin passes through a two-flop synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier. When that comparison shows the edge picked for the pin, the pin's sticky flag is set. Each pin has one bit in each of three registers: a polarity select bit (1 selects rising edges, 0 selects falling edges), an enable bit and a flag bit.

Software reads and writes the three registers over a plain synchronous bus that has an address, a write strobe, write data and a combinational read data path. A flag bit is cleared by writing 1 to it. A single level-sensitive interrupt request is raised while any pin has both its flag and its enable bit set. The enable bit gates only the request. A disabled pin therefore still records its edges, and its request appears as soon as the pin is enabled.

Register offsets, with a 10-bit address: polarity select at 0x26D, enable at 0x26E, flag at 0x26F. Bit i of each register belongs to pin i.

Top module: `edgeirq_port`

## Requirements
- R1: After reset, the polarity, enable and flag registers all read 0x00 and irq_o is 0.
- R2: With its polarity bit at 1, a pin's flag is set by a 0-to-1 transition and is not set by a 1-to-0 transition.
- R3: With its polarity bit at 0, a pin's flag is set by a 1-to-0 transition and is not set by a 0-to-1 transition.
- R4: Writing the flag register clears each flag whose write-data bit is 1. Bits written as 0 keep their value.
- R5: irq_o is 1 exactly when, for some pin, both the flag bit and the enable bit are 1.
- R6: A pin whose enable bit is 0 still has its flag set by active edges. Setting the enable bit afterwards raises irq_o.
- R7: When an active edge and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: Writing the polarity register while the pins are stable sets no flag.
- R9: A read at any offset other than the three register offsets returns 0x00. A write to such an offset changes no register.
- R10: The polarity and enable registers can be written at any time and read back with the written value.
- R11: A pin change driven before clock edge k is visible in the flag register after clock edge k+2 (two synchronizer stages plus the flag register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | N_PINS (8) | Asynchronous pin levels |
| bus_addr | input | ADDR_W (10) | Register offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | N_PINS (8) | Write data |
| bus_rdata | output | N_PINS (8) | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives both edge directions under both polarity settings. A detector that ignored polarity, or that used the wrong sense, would set flags on the wrong transitions. It times a write-1 clear to land in the same cycle in which a new edge reaches the flag register. A design that gave priority to the clear would lose that edge and read back 0. It also rewrites the polarity register while the pins are idle. A detector that compared polarity-adjusted levels would see a false edge and set a flag. Finally, it checks that a flag captured while its pin was disabled raises the request once the enable bit is set, and that writes to unmapped offsets leave the real registers unchanged.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_POL,
        SEL_EN,
        SEL_FLAG
    } reg_sel_e;
endpackage

// File: rtl/edgeirq_decode.sv
module edgeirq_decode
    import edgeirq_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int POL_ADDR  = 'h26D,
    parameter int EN_ADDR   = 'h26E,
    parameter int FLAG_ADDR = 'h26F
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] POL_A  = ADDR_W'(POL_ADDR);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    always_comb begin
        if (addr == POL_A)       sel = SEL_POL;
        else if (addr == EN_A)   sel = SEL_EN;
        else if (addr == FLAG_A) sel = SEL_FLAG;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/edgeirq_sync.sv
module edgeirq_sync #(
    parameter int N_PINS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_in,
    input  logic [N_PINS-1:0] pol,
    output logic [N_PINS-1:0] sync_now,
    output logic [N_PINS-1:0] sync_prev,
    output logic [N_PINS-1:0] edge_hit
);
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], pins_in[g]};
                last  <= chain[SYNC_STAGES-1];
            end
        end

        assign sync_now[g]  = chain[SYNC_STAGES-1];
        assign sync_prev[g] = last;
        // Compare raw synchronized levels; polarity only selects which change counts.
        assign edge_hit[g]  = pol[g] ? (sync_now[g] & ~last)
                                     : (~sync_now[g] & last);
    end
endmodule

// File: rtl/edgeirq_regs.sv
module edgeirq_regs
    import edgeirq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              we,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] edge_hit,
    output logic [N_PINS-1:0] rdata,
    output logic [N_PINS-1:0] pol_q,
    output logic [N_PINS-1:0] en_q,
    output logic [N_PINS-1:0] flag_q,
    output logic              irq
);
    logic [N_PINS-1:0] clr_mask;

    assign clr_mask = (we && sel == SEL_FLAG) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '0;
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (we && sel == SEL_POL) pol_q <= wdata;
            if (we && sel == SEL_EN)  en_q  <= wdata;
            // set has priority over clear
            flag_q <= (flag_q & ~clr_mask) | edge_hit;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_POL:  rdata = pol_q;
            SEL_EN:   rdata = en_q;
            SEL_FLAG: rdata = flag_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = |(flag_q & en_q);
endmodule

// File: rtl/edgeirq_port.sv
module edgeirq_port
    import edgeirq_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int POL_ADDR    = 'h26D,
    parameter int EN_ADDR     = 'h26E,
    parameter int FLAG_ADDR   = 'h26F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic              irq_o
);
    reg_sel_e          sel;
    logic [N_PINS-1:0] pol_q;
    logic [N_PINS-1:0] en_q;
    logic [N_PINS-1:0] flag_q;
    logic [N_PINS-1:0] sync_now;
    logic [N_PINS-1:0] sync_prev;
    logic [N_PINS-1:0] edge_hit;

    edgeirq_decode #(
        .ADDR_W(ADDR_W), .POL_ADDR(POL_ADDR),
        .EN_ADDR(EN_ADDR), .FLAG_ADDR(FLAG_ADDR)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    edgeirq_sync #(
        .N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  (pins_in),
        .pol      (pol_q),
        .sync_now (sync_now),
        .sync_prev(sync_prev),
        .edge_hit (edge_hit)
    );

    edgeirq_regs #(
        .N_PINS(N_PINS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .edge_hit(edge_hit),
        .rdata   (bus_rdata),
        .pol_q   (pol_q),
        .en_q    (en_q),
        .flag_q  (flag_q),
        .irq     (irq_o)
    );
endmodule

// File: rtl/edgeirq_port_chk.sv
module edgeirq_port_chk #(
    parameter int N_PINS    = 8,
    parameter int ADDR_W    = 10,
    parameter int POL_ADDR  = 'h26D,
    parameter int EN_ADDR   = 'h26E,
    parameter int FLAG_ADDR = 'h26F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] bus_rdata,
    input logic              irq_o,
    input logic [N_PINS-1:0] pol_q,
    input logic [N_PINS-1:0] en_q,
    input logic [N_PINS-1:0] flag_q,
    input logic [N_PINS-1:0] sync_now,
    input logic [N_PINS-1:0] sync_prev
);
    localparam logic [ADDR_W-1:0] POL_A  = ADDR_W'(POL_ADDR);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    // R9: unmapped offsets read as zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != POL_A && bus_addr != EN_A && bus_addr != FLAG_A) |-> bus_rdata == '0);

    // R10: enable changes only by a write to its offset
    p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we && bus_addr == EN_A) |-> en_q == $past(en_q));

    // R8: polarity changes only by a write to its offset
    p_pol_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we && bus_addr == POL_A) |-> pol_q == $past(pol_q));

    // R4: a flag falls only under a write-1 to its bit
    p_clear_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_q) & ~flag_q) &
         ~($past(bus_we && bus_addr == FLAG_A) ? $past(bus_wdata) : {N_PINS{1'b0}})) == '0);

    // R2: a flag rises only where the synchronized pin changed
    p_set_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q)) & ~$past(sync_now ^ sync_prev)) == '0);

    // R7: an active edge always leaves its flag set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past((sync_now ^ sync_prev) & ~(sync_now ^ pol_q)) & ~flag_q) == '0);

    // R5: request only with a flagged and enabled pin
    p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_q & en_q) != '0);
endmodule

bind edgeirq_port edgeirq_port_chk #(
    .N_PINS(N_PINS), .ADDR_W(ADDR_W), .POL_ADDR(POL_ADDR),
    .EN_ADDR(EN_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .pol_q    (pol_q),
    .en_q     (en_q),
    .flag_q   (flag_q),
    .sync_now (sync_now),
    .sync_prev(sync_prev)
);

// File: tb/edgeirq_port_bench.sv
`timescale 1ns/1ps
module edgeirq_port_bench;
    localparam int N  = 8;
    localparam int AW = 10;
    localparam logic [AW-1:0] A_POL  = 10'h26D;
    localparam logic [AW-1:0] A_EN   = 10'h26E;
    localparam logic [AW-1:0] A_FLAG = 10'h26F;
    localparam int NV = 10;

    // {we, addr, wdata, expected read}
    localparam logic [26:0] VEC [0:NV-1] = '{
        {1'b1, A_EN,   8'h5A, 8'h00},
        {1'b0, A_EN,   8'h00, 8'h5A},
        {1'b1, A_POL,  8'hC3, 8'h00},
        {1'b0, A_POL,  8'h00, 8'hC3},
        {1'b1, 10'h270, 8'hFF, 8'h00},
        {1'b0, 10'h270, 8'h00, 8'h00},
        {1'b0, 10'h000, 8'h00, 8'h00},
        {1'b0, A_EN,   8'h00, 8'h5A},
        {1'b1, A_FLAG, 8'hFF, 8'h00},
        {1'b0, A_FLAG, 8'h00, 8'h00}
    };
    string vec_tag [0:NV-1] = '{"R10", "R10", "R10", "R10", "R9",
                                "R9", "R9", "R9", "R4", "R4"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    edgeirq_port u_edgeirq_port (
        .clk(clk), .rst_n(rst_n), .pins_in(pins), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [N-1:0] exp);
        @(negedge clk);
        addr = a;
        #1 check(tag, rdata, exp);
    endtask

    // drive pins, then wait past the two sync stages and the flag register
    task automatic drive_pins(input logic [N-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 0x00 expected 0x01");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd("R1", A_POL, 8'h00);
        rd("R1", A_EN, 8'h00);
        rd("R1", A_FLAG, 8'h00);
        check("R1", {7'd0, irq}, 8'h00);

        // register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][26]) wr(VEC[i][25:16], VEC[i][15:8]);
            else            rd(vec_tag[i], VEC[i][25:16], VEC[i][7:0]);
        end
        wr(A_EN, 8'h00);
        wr(A_POL, 8'h00);

        // R3 falling polarity on pin 0
        drive_pins(8'h01);
        rd("R3", A_FLAG, 8'h00);
        drive_pins(8'h00);
        rd("R3", A_FLAG, 8'h01);

        // R2 rising polarity on pin 1
        wr(A_POL, 8'hFF);
        drive_pins(8'h02);
        rd("R2", A_FLAG, 8'h03);
        drive_pins(8'h00);
        rd("R2", A_FLAG, 8'h03);

        // R6 captured while disabled, request once enabled
        check("R6", {7'd0, irq}, 8'h00);
        wr(A_EN, 8'h02);
        #1 check("R6", {7'd0, irq}, 8'h01);

        // R4 write-one-to-clear
        wr(A_FLAG, 8'h00);
        rd("R4", A_FLAG, 8'h03);
        wr(A_FLAG, 8'h01);
        rd("R4", A_FLAG, 8'h02);
        check("R5", {7'd0, irq}, 8'h01);
        wr(A_FLAG, 8'h02);
        rd("R4", A_FLAG, 8'h00);
        check("R5", {7'd0, irq}, 8'h00);

        // R8 polarity rewrites with idle pins
        wr(A_POL, 8'h00);
        wr(A_POL, 8'h55);
        wr(A_POL, 8'hFF);
        repeat (4) @(negedge clk);
        rd("R8", A_FLAG, 8'h00);

        // R11 latency: not yet after edge k+1, set after edge k+2
        @(negedge clk);
        pins = 8'h04;
        repeat (2) @(negedge clk);
        addr = A_FLAG;
        #1 check("R11", rdata, 8'h00);
        @(negedge clk);
        #1 check("R11", rdata, 8'h04);
        drive_pins(8'h00);

        // R7 edge and clear in the same cycle
        @(negedge clk);
        pins = 8'h04;
        @(negedge clk);
        @(negedge clk);
        addr = A_FLAG; wdata = 8'h04; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        rd("R7", A_FLAG, 8'h04);

        // R5 request from any enabled pin
        wr(A_EN, 8'hFF);
        #1 check("R5", {7'd0, irq}, 8'h01);
        wr(A_FLAG, 8'hFF);
        #1 check("R5", {7'd0, irq}, 8'h00);

        finish_run();
    end
endmodule